// File: doc/BRIEF.md
# Push-Pull Latching PWM Controller

This block produces two gate-drive enables for a push-pull power stage. A free-running counter ramp sets the switching period. At the start of every period a clock pulse of programmable width blanks both outputs. That pulse forms the deadtime and also flips a phase flop, so that successive periods are steered alternately to output A and output B. Within a period the active output rises when the blanking ends. It falls when the ramp reaches the effective compare level, or earlier if shutdown or lockout intervenes. A set-dominant latch holds the output off until the next clock pulse, so each period carries at most one pulse.

The effective compare level is the smaller of the duty command and a soft-start level. It is loaded only on the first edge of each period. The soft-start level climbs by one count every `ssRate + 1` periods and saturates at full scale. While shutdown is held it falls by `SS_DROP` counts on every clock and saturates at zero. A short shutdown therefore cuts one pulse and leaves the duty untouched. A long one drains the level and forces a slow restart. Undervoltage lockout blanks both outputs at once and freezes the soft-start level. A sync input restarts the ramp so that several units can share one period.

Top module: `pwm_pushpull`

## Requirements
- R1: outA and outB are never high in the same cycle. Successive output pulses alternate between A and B, one period apiece.
- R2: Each output is the NOR of the clock pulse, its own phase (phase 0 selects A, phase 1 selects B), the pulse latch and lockout. An output whose phase is inactive stays low for the whole period.
- R3: The ramp counts 0 up to periodLen and then restarts at 0. clkPulse is high while the ramp is at most deadLen, which is deadLen+1 cycles per period. Both outputs are low throughout clkPulse.
- R4: In steady state the active output is high for max(0, min(level, periodLen) - deadLen) cycles per period, where level = min(dutyCmd, soft-start level). This is below half of the two-period cycle of each output.
- R5: The pulse latch is set when the ramp reaches the compare level and is cleared only by clkPulse. Setting wins over clearing. Once an output falls it stays low for the rest of its period.
- R6: Asserting shutdown drives both outputs low from the next clock edge. After shutdown is released they stay low until the next clock pulse.
- R7: On every clock with shutdown high, the soft-start level drops by SS_DROP counts (default 4), with a floor of 0. A one-cycle shutdown leaves the following pulses at full width. After a shutdown of 100 cycles, with ssRate = 0 and deadLen = 2, the next three pulses last 1, 2 and 3 cycles.
- R8: With uvlo high, both outputs are low in the same cycle and the soft-start level does not rise. After uvlo is released with ssRate = 1, deadLen = 2 and a drained level, the pulses last 1, 1, 2, 2 cycles.
- R9: A cycle with syncIn high restarts the ramp at 0 on the next edge. That starts a new period with clkPulse and flips the phase.
- R10: The compare level is loaded on each period start from min(dutyCmd, soft-start level), using the level from before that edge. The level rises by 1 every ssRate+1 periods and saturates at all ones.
- R11: During and after reset the ramp and the soft-start level are 0, clkPulse is high and both outputs are low. The first pulse after reset appears on outA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| periodLen | input | CNT_W | Top count of the ramp; the period is periodLen+1 cycles |
| deadLen | input | CNT_W | Clock pulse spans ramp values 0..deadLen |
| dutyCmd | input | CNT_W | Ramp count at which the pulse ends |
| ssRate | input | RATE_W | Soft-start rises once every ssRate+1 periods |
| shutdown | input | 1 | Cuts pulses and drains soft-start |
| uvlo | input | 1 | Undervoltage lockout: blanks outputs, freezes soft-start |
| syncIn | input | 1 | Restarts the ramp on the next edge |
| outA | output | 1 | Drive enable for output A |
| outB | output | 1 | Drive enable for output B |
| clkPulse | output | 1 | Period-start blanking pulse |

## Verification
The ramp, phase, latch and compare level are registers, while the outputs are a combinational NOR of them. The effect of shutdown and of the ramp reaching the compare level therefore shows one edge later, and uvlo shows in the same cycle. A new duty or soft-start value shows only in the period after the next ramp restart. The bench drives and samples on the falling edge. For lockout it samples 1 ns after driving. Pulse widths are measured as runs of high samples over whole two-period windows after a settling delay of several periods, so every check falls after the restart that loads the new compare level. Soft-start sequences are counted from the first ramp restart after release.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // strobes passed from control to datapath
  typedef struct packed {
    logic wrap;     // ramp restarts on the next edge
    logic blank;    // clock pulse active
    logic phase;    // 0 selects output A, 1 selects B
    logic kill;     // set the pulse latch unconditionally
    logic lockout;  // immediate output inhibit
  } pwm_strobe_t;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int RATE_W  = 4,
  parameter int SS_DROP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  periodLen,
  input  logic [CNT_W-1:0]  deadLen,
  input  logic [RATE_W-1:0] ssRate,
  input  logic              shutdown,
  input  logic              uvlo,
  input  logic              syncIn,
  output logic [CNT_W-1:0]  ramp,
  output logic [CNT_W-1:0]  ssLvl,
  output pwm_strobe_t       strobe
);
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] DROP = CNT_W'(SS_DROP);

  logic [CNT_W-1:0]  rampQ;
  logic [CNT_W-1:0]  ssQ;
  logic [RATE_W-1:0] ssCntQ;
  logic              phaseQ;
  logic              wrap;
  logic [CNT_W-1:0]  ssUp;
  logic [CNT_W-1:0]  ssDown;

  assign wrap   = syncIn | (rampQ >= periodLen);
  assign ssUp   = (ssQ == FULL) ? FULL : ssQ + 1'b1;
  assign ssDown = (ssQ < DROP) ? '0 : ssQ - DROP;

  // ramp oscillator and steering flop
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rampQ  <= '0;
      phaseQ <= 1'b0;
    end else begin
      rampQ <= wrap ? '0 : rampQ + 1'b1;
      if (wrap) phaseQ <= ~phaseQ;
    end
  end

  // soft-start level
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ssQ    <= '0;
      ssCntQ <= '0;
    end else if (shutdown) begin
      ssQ    <= ssDown;
      ssCntQ <= '0;
    end else if (uvlo) begin
      ssCntQ <= '0;
    end else if (wrap) begin
      if (ssCntQ == ssRate) begin
        ssCntQ <= '0;
        ssQ    <= ssUp;
      end else begin
        ssCntQ <= ssCntQ + 1'b1;
      end
    end
  end

  assign ramp           = rampQ;
  assign ssLvl          = ssQ;
  assign strobe.wrap    = wrap;
  assign strobe.blank   = (rampQ <= deadLen);
  assign strobe.phase   = phaseQ;
  assign strobe.kill    = shutdown | uvlo;
  assign strobe.lockout = uvlo;

  AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    syncIn |=> (ramp == '0) && strobe.blank); // R9
  AST_SS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (uvlo && !shutdown) |=> ssLvl == $past(ssLvl)); // R8
  AST_SS_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> ssLvl <= $past(ssLvl)); // R7
endmodule

// File: rtl/pwm_dp.sv
module pwm_dp
  import pwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] ramp,
  input  logic [CNT_W-1:0] ssLvl,
  input  logic [CNT_W-1:0] dutyCmd,
  input  pwm_strobe_t      strobe,
  output logic             outA,
  output logic             outB
);
  logic [CNT_W-1:0] cmpQ;
  logic [CNT_W-1:0] effLvl;
  logic             latchQ;
  logic             setLatch;

  assign effLvl   = (dutyCmd < ssLvl) ? dutyCmd : ssLvl;
  assign setLatch = (ramp >= cmpQ) | strobe.kill;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmpQ   <= '0;
      latchQ <= 1'b1;
    end else begin
      if (strobe.wrap) cmpQ <= effLvl;
      latchQ <= setLatch | (latchQ & ~strobe.blank);
    end
  end

  assign outA = ~(strobe.blank | strobe.phase  | latchQ | strobe.lockout);
  assign outB = ~(strobe.blank | ~strobe.phase | latchQ | strobe.lockout);

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(outA && outB)); // R1
  AST_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.blank |-> !outA && !outB); // R3
  AST_KILL_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.kill |=> !outA && !outB); // R6
  AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.lockout |-> !outA && !outB); // R8
  AST_ONE_PULSE_A: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(outA) |=> !outA); // R5
  AST_ONE_PULSE_B: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(outB) |=> !outB); // R5
endmodule

// File: rtl/pwm_pushpull.sv
module pwm_pushpull
  import pwm_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int RATE_W  = 4,
  parameter int SS_DROP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  periodLen,
  input  logic [CNT_W-1:0]  deadLen,
  input  logic [CNT_W-1:0]  dutyCmd,
  input  logic [RATE_W-1:0] ssRate,
  input  logic              shutdown,
  input  logic              uvlo,
  input  logic              syncIn,
  output logic              outA,
  output logic              outB,
  output logic              clkPulse
);
  logic [CNT_W-1:0] ramp;
  logic [CNT_W-1:0] ssLvl;
  pwm_strobe_t      strobe;

  pwm_ctrl #(.CNT_W(CNT_W), .RATE_W(RATE_W), .SS_DROP(SS_DROP)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .periodLen(periodLen), .deadLen(deadLen),
    .ssRate(ssRate), .shutdown(shutdown), .uvlo(uvlo), .syncIn(syncIn),
    .ramp(ramp), .ssLvl(ssLvl), .strobe(strobe)
  );

  pwm_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ramp(ramp), .ssLvl(ssLvl),
    .dutyCmd(dutyCmd), .strobe(strobe), .outA(outA), .outB(outB)
  );

  assign clkPulse = strobe.blank;
endmodule

// File: tb/tb_pwm_pushpull.sv
module tb_pwm_pushpull;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] periodLen = 8'd7;
  logic [7:0] deadLen = 8'd0;
  logic [7:0] dutyCmd = 8'd5;
  logic [3:0] ssRate = 4'd0;
  logic       shutdown = 1'b0;
  logic       uvlo = 1'b0;
  logic       syncIn = 1'b0;
  logic       outA, outB, clkPulse;

  int checks = 0;
  int errors = 0;
  int runLen [8];
  bit runIsA [8];
  int runCount;

  always #4 clk = ~clk;

  pwm_pushpull dut (
    .clk(clk), .rst_n(rst_n), .periodLen(periodLen), .deadLen(deadLen),
    .dutyCmd(dutyCmd), .ssRate(ssRate), .shutdown(shutdown), .uvlo(uvlo),
    .syncIn(syncIn), .outA(outA), .outB(outB), .clkPulse(clkPulse)
  );

  // {periodLen, deadLen, dutyCmd, expected width}
  localparam logic [31:0] VEC [0:8] = '{
    {8'd15, 8'd2,  8'd8,   8'd6},
    {8'd15, 8'd2,  8'd0,   8'd0},
    {8'd15, 8'd2,  8'd15,  8'd13},
    {8'd15, 8'd2,  8'd200, 8'd13},
    {8'd31, 8'd4,  8'd20,  8'd16},
    {8'd31, 8'd0,  8'd10,  8'd10},
    {8'd9,  8'd9,  8'd5,   8'd0},
    {8'd20, 8'd3,  8'd3,   8'd0},
    {8'd63, 8'd10, 8'd40,  8'd30}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic collectRuns(input int n, input int limit);
    int idx = 0;
    int cur = 0;
    int cyc = 0;
    bit seenLow = 0;
    bit hi;
    while (idx < n && cyc < limit) begin
      @(negedge clk);
      cyc++;
      hi = outA | outB;
      if (!seenLow) begin
        if (!hi) seenLow = 1;
      end else if (hi) begin
        if (cur == 0) runIsA[idx] = outA;
        cur++;
      end else if (cur > 0) begin
        runLen[idx] = cur;
        idx++;
        cur = 0;
      end
    end
    runCount = idx;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cntA, cntB, cntClk, cntBoth, hiCnt;
    // R11: reset state
    repeat (5) @(negedge clk);
    chk(!outA && !outB && clkPulse, "R11 reset outputs", {outA, outB, clkPulse}, 3'b001);
    rst_n = 1'b1;

    // R11 first pulse on A, R10 soft-start ramp, R1 alternation
    collectRuns(6, 400);
    chk(runCount == 6, "R10 run count", runCount, 6);
    chk(runIsA[0], "R11 first pulse on A", runIsA[0], 1);
    for (int i = 0; i < 6; i++) begin
      int exp;
      exp = (i < 5) ? i + 1 : 5;
      chk(runLen[i] == exp, "R10 soft-start run", runLen[i], exp);
      if (i > 0) chk(runIsA[i] != runIsA[i-1], "R1 alternation", runIsA[i], !runIsA[i-1]);
    end

    // saturate soft-start
    periodLen = 8'd15; deadLen = 8'd2; dutyCmd = 8'd8;
    repeat (4800) @(negedge clk);

    // table of steady-state widths: R2 R3 R4
    for (int v = 0; v < 9; v++) begin
      int win, expW;
      periodLen = VEC[v][31:24];
      deadLen   = VEC[v][23:16];
      dutyCmd   = VEC[v][15:8];
      expW      = int'(VEC[v][7:0]);
      repeat (600) @(negedge clk);
      win = 2 * (int'(periodLen) + 1);
      cntA = 0; cntB = 0; cntClk = 0; cntBoth = 0;
      for (int c = 0; c < win; c++) begin
        @(negedge clk);
        cntA += outA;
        cntB += outB;
        cntClk += clkPulse;
        cntBoth += (outA & outB);
      end
      chk(cntA == expW, "R4 width A", cntA, expW);
      chk(cntB == expW, "R2 width B", cntB, expW);
      chk(cntClk == 2 * (int'(deadLen) + 1), "R3 clock pulse width", cntClk, 2 * (int'(deadLen) + 1));
      chk(cntBoth == 0, "R1 overlap", cntBoth, 0);
    end

    // R6 / R5: cut mid-pulse, stay off rest of period
    periodLen = 8'd31; deadLen = 8'd2; dutyCmd = 8'd20;
    repeat (600) @(negedge clk);
    while (!outA) @(negedge clk);
    repeat (3) @(negedge clk);
    shutdown = 1'b1;
    @(negedge clk);
    chk(!outA && !outB, "R6 immediate cut", outA, 0);
    shutdown = 1'b0;
    hiCnt = 0;
    for (int c = 0; c < 64 && !clkPulse; c++) begin
      hiCnt += (outA | outB);
      @(negedge clk);
    end
    chk(hiCnt == 0, "R5 no second pulse", hiCnt, 0);
    collectRuns(2, 200);
    chk(runLen[0] == 18, "R7 brief shutdown run0", runLen[0], 18);
    chk(runLen[1] == 18, "R7 brief shutdown run1", runLen[1], 18);

    // R7 long shutdown
    shutdown = 1'b1;
    hiCnt = 0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      hiCnt += (outA | outB);
    end
    chk(hiCnt == 0, "R6 held off", hiCnt, 0);
    shutdown = 1'b0;
    collectRuns(3, 600);
    for (int i = 0; i < 3; i++)
      chk(runLen[i] == i + 1, "R7 slow restart", runLen[i], i + 1);

    // R8 lockout
    while (!(outA | outB)) @(negedge clk);
    uvlo = 1'b1;
    #1;
    chk(!outA && !outB, "R8 same-cycle blank", outA | outB, 0);
    shutdown = 1'b1;
    repeat (100) @(negedge clk);
    shutdown = 1'b0;
    hiCnt = 0;
    for (int c = 0; c < 1280; c++) begin
      @(negedge clk);
      hiCnt += (outA | outB);
    end
    chk(hiCnt == 0, "R8 held low", hiCnt, 0);
    ssRate = 4'd1;
    uvlo = 1'b0;
    collectRuns(4, 800);
    chk(runLen[0] == 1, "R8 frozen soft-start run0", runLen[0], 1);
    chk(runLen[1] == 1, "R10 rate run1", runLen[1], 1);
    chk(runLen[2] == 2, "R10 rate run2", runLen[2], 2);
    chk(runLen[3] == 2, "R10 rate run3", runLen[3], 2);

    // R9 sync
    ssRate = 4'd0;
    repeat (1500) @(negedge clk);
    cntA = 0; cntB = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (i == 10)
        chk(clkPulse && !outA && !outB, "R9 sync restart", clkPulse, 1);
      if (i >= 40) begin
        cntA += outA;
        cntB += outB;
      end
      syncIn = (i % 10 == 9);
    end
    syncIn = 1'b0;
    chk(cntA == 7, "R9 synced width A", cntA, 7);
    chk(cntB == 7, "R9 synced width B", cntB, 7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule